// File: doc/BRIEF.md
# Write-Progress Status Read Multiplexer

This block sits on the read path of a byte-wide non-volatile memory that writes in two stages. First, a byte-load window collects bytes. Then an internally timed programming phase commits them. When no write is in flight, a read returns the stored byte at the addressed location unchanged. When a write is loading or programming, the same read returns a status byte instead. That byte lets software poll for completion without any dedicated status register.

The status byte carries five indicators, each on a fixed lane:

| Lane | Indicator | Meaning |
|------|-----------|---------|
| 7 | Polling | Inverse of bit 7 of the most recently loaded byte while programming runs. |
| 6 | Toggle | Flips on each read during programming. |
| 5 | Phase | Tells loading apart from programming. |
| 1 | Abort | Page-change abort flag. |
| 0 | Protection | Write-protection state. |

Lanes 4 to 2 read as zero. The write controller and the command decoder that produce the phase, abort and protection flags are outside this block.

Reads are single-cycle strobes. Read data is registered and appears on the cycle after the strobe. It holds until the next strobe.

Top module: `wr_status_mux`

## Requirements
- R1: With neither the load window nor programming active, a read returns the array byte supplied for the read address.
- R2: Lane 7 of a status read is the inverse of bit 7 of the last loaded byte while programming, and its true value during the load window.
- R3: During programming, lane 6 starts at 0 on the first read and inverts on each further read.
- R4: Lane 6 restarts at 0 at the beginning of every new programming phase, including when no read occurred in between.
- R5: Lane 5 reads 0 during the load window and 1 during programming.
- R6: Lane 1 reports the abort flag in any status read, whether protection is on or off.
- R7: Lane 0 reports the protection flag in a status read: 1 means enabled, 0 means disabled.
- R8: Lanes 4, 3 and 2 read 0 in every status read.
- R9: Once programming ends, reads return array data again and the toggle no longer appears.
- R10: After reset the read data is 0, and it changes only on the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | ADDR_W | Read address |
| arr_addr | output | ADDR_W | Address forwarded to the array read port |
| arr_data | input | DATA_W | Array byte for arr_addr |
| last_byte | input | DATA_W | Most recent byte latched by the load logic |
| load_active | input | 1 | Byte-load window open |
| prog_active | input | 1 | Internal programming phase running |
| abort_flag | input | 1 | Page-change abort detected |
| prot_flag | input | 1 | Write protection enabled |
| rd_data | output | DATA_W | Registered read data |

## Verification
The hardest case to reach is the restart of the toggle lane. It needs a programming phase that ends with the toggle state at 1. A second phase must then begin, with a read placed on the very cycle that phase rises, and another phase must begin with no read at all before the first poll. The stimulus produces these cases by toggling the phase input on chosen falling edges and counting reads, so that each phase ends in a known toggle state.

// File: rtl/wr_status_mux.sv
module wr_status_mux #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic [DATA_W-1:0] last_byte,
  input  logic              load_active,
  input  logic              prog_active,
  input  logic              abort_flag,
  input  logic              prot_flag,
  output logic [DATA_W-1:0] rd_data
);
  localparam int L_POLL = 7;
  localparam int L_TOG  = 6;
  localparam int L_PH   = 5;
  localparam int L_ABT  = 1;
  localparam int L_PROT = 0;

  logic prog_q, tog, start, busy, tog_now;
  logic [DATA_W-1:0] status;

  assign arr_addr = rd_addr;
  assign start    = prog_active & ~prog_q;
  assign busy     = load_active | prog_active;
  assign tog_now  = prog_active & ~start & tog;

  always_comb begin
    status         = '0;
    status[L_POLL] = last_byte[L_POLL] ^ prog_active;
    status[L_TOG]  = tog_now;
    status[L_PH]   = prog_active;
    status[L_ABT]  = abort_flag;
    status[L_PROT] = prot_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b0;
      tog    <= 1'b0;
    end else begin
      prog_q <= prog_active;
      if (start)                   tog <= rd_en;
      else if (rd_en && prog_active) tog <= ~tog;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= busy ? status : arr_data;
  end
endmodule

module wr_status_mux_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [DATA_W-1:0] arr_data,
  input logic [DATA_W-1:0] last_byte,
  input logic              load_active,
  input logic              prog_active,
  input logic              prot_flag,
  input logic [DATA_W-1:0] rd_data
);
  a_r1_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !load_active && !prog_active |=> rd_data == $past(arr_data));
  a_r2_poll_inv: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && prog_active |=> rd_data[7] != $past(last_byte[7]));
  a_r5_phase: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (load_active || prog_active) |=> rd_data[5] == $past(prog_active));
  a_r7_prot: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (load_active || prog_active) |=> rd_data[0] == $past(prot_flag));
  a_r8_zero_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (load_active || prog_active) |=> rd_data[4:2] == 3'b000);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind wr_status_mux wr_status_mux_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .arr_data(arr_data),
  .last_byte(last_byte), .load_active(load_active), .prog_active(prog_active),
  .prot_flag(prot_flag), .rd_data(rd_data));

// File: tb/wr_status_mux_tb.sv
module wr_status_mux_tb_top;
  logic        clk = 0, rst_n = 0, rd_en = 0;
  logic [16:0] rd_addr = '0, arr_addr;
  logic [7:0]  arr_data, last_byte = '0, rd_data;
  logic        load_active = 0, prog_active = 0, abort_flag = 0, prot_flag = 0;
  int runs = 0, fails = 0;

  always #4 clk = ~clk;
  assign arr_data = arr_addr[7:0] ^ 8'h5A;

  wr_status_mux dut_i (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .arr_addr(arr_addr), .arr_data(arr_data), .last_byte(last_byte),
    .load_active(load_active), .prog_active(prog_active), .abort_flag(abort_flag),
    .prot_flag(prot_flag), .rd_data(rd_data));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [16:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic t_reset;
    chk("R10 reset", rd_data, 8'h00);
  endtask

  task automatic t_idle;
    logic [7:0] d;
    rd(17'h00123, d); chk("R1 idle a", d, 8'h23 ^ 8'h5A);
    rd(17'h1FFFF, d); chk("R1 idle b", d, 8'hFF ^ 8'h5A);
    repeat (3) @(negedge clk);
    chk("R10 hold", rd_data, 8'hFF ^ 8'h5A);
  endtask

  task automatic t_load;
    logic [7:0] d;
    @(negedge clk); load_active = 1; last_byte = 8'h80; prot_flag = 0; abort_flag = 0;
    rd(17'h00010, d); chk("R2 R5 R8 load", d, 8'h80);
    abort_flag = 1; prot_flag = 1;
    rd(17'h00010, d); chk("R6 R7 abort prot on", d, 8'h83);
    prot_flag = 0;
    rd(17'h00010, d); chk("R6 abort prot off", d, 8'h82);
    @(negedge clk); load_active = 0; abort_flag = 0;
  endtask

  task automatic t_prog;
    logic [7:0] d;
    last_byte = 8'h80; prot_flag = 1;
    @(negedge clk); prog_active = 1; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
    chk("R2 R3 R5 first", d, 8'h21);
    rd(17'h0, d); chk("R3 second", d, 8'h61);
    rd(17'h0, d); chk("R3 third", d, 8'h21);
    rd(17'h0, d); chk("R3 fourth", d, 8'h61);
    @(negedge clk); prog_active = 0;
    rd(17'h00044, d); chk("R9 done", d, 8'h44 ^ 8'h5A);
    last_byte = 8'h00;
    @(negedge clk); prog_active = 1; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
    chk("R4 restart read-on-start", d, 8'hA1);
    @(negedge clk); prog_active = 0;
    @(negedge clk); prog_active = 1;
    @(negedge clk);
    rd(17'h0, d); chk("R4 restart no read", d, 8'hA1);
    rd(17'h0, d); chk("R3 after restart", d, 8'hE1);
    @(negedge clk); prog_active = 0; prot_flag = 0;
    rd(17'h00007, d); chk("R9 done again", d, 8'h07 ^ 8'h5A);
  endtask

  initial begin
    #2000000;
    fails++; runs++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_idle;
    t_load;
    t_prog;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule